// File: doc/BRIEF.md
# Biphase Mark Frame Serializer

This block turns a short request into a complete line frame for a USB Power Delivery style baseband link. A frame is either a hard-reset frame or a data frame. Both open with an alternating preamble and close with a tail that leaves one final transition and parks the line low. The hard-reset frame carries a fixed ordered set. The data frame carries a number of 32-bit words, and every nibble of each word passes through the 4b5b code. All bits go onto the line in biphase mark coding.

The block runs at the system clock. It advances one half bit cell on each cycle where `half_tick` is high. It draws words from an external source: `word_next` pulses each time a word has been captured, so the source can present the next one. CRC, start-of-packet ordered sets and the analog driver are outside the block.

Top module: `pd_bmc_tx`

## Requirements
- R1: After reset `line_o` is 0, and `busy_o`, `done_o` and `word_next_o` are all 0.
- R2: Each bit takes two half-cell ticks. The line toggles on the first tick of every bit, and toggles again on the second tick only when the bit is 1. The line changes only on cycles with `half_tick` high, and it ignores `half_tick` while no frame is in progress.
- R3: Every frame begins with 64 preamble bits that alternate, starting with 0 (0,1,0,1,...).
- R4: With `frame_hrst_i`=1 the payload is the symbol 5'b00111 three times, followed by 5'b11001 once. Each 5-bit symbol is sent least significant bit first.
- R5: With `frame_hrst_i`=0, each word is sent as eight nibbles, from bits [3:0] up to [31:28], so the low 16 bits go out before the high 16 bits. Each nibble is mapped to 5 bits, LSB first, by this table (written MSB..LSB): 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R6: After the last payload bit comes a two-tick tail. The first tail tick toggles the line and the second drives it to 0. The line then stays 0 until the next frame.
- R7: `busy_o` rises in the cycle after an accepted `start_i`. `done_o` is a one-cycle pulse in the cycle after the last tail tick, and `busy_o` falls in that same cycle. A frame with S symbols takes exactly 2*(64+5*S)+2 ticks.
- R8: A data frame with `word_count_i`=N pulses `word_next_o` exactly N times. The first pulse comes in the cycle after `start_i`, and each pulse marks `word_in_i` as captured. With N=0 the tail follows the preamble directly.
- R9: `start_i`, `frame_hrst_i` and `word_count_i` are ignored while `busy_o` is high.
- R10: A hard-reset frame ignores `word_count_i` and never pulses `word_next_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Enable, one pulse per half bit cell |
| start_i | input | 1 | Frame request, taken when idle |
| frame_hrst_i | input | 1 | 1 selects hard-reset frame, 0 data frame |
| word_count_i | input | WORDS_W | Number of data words in the frame |
| word_in_i | input | 32 | Current data word |
| word_next_o | output | 1 | Pulse: `word_in_i` captured, present the next word |
| line_o | output | 1 | Coded line level |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The bench decodes nothing. It rebuilds the expected line level after every half-cell tick from the bit stream the requirements define, and compares the two in the preamble and in the payload separately.

It sends hard-reset frames, and data frames of zero, one, two and three words. The word values cover every nibble value, runs of all ones, runs of all zeros, and mixed patterns. The zero-word frame separates the preamble-to-tail path from the symbol path. The all-ones and all-zeros words separate the mid-bit toggle from the boundary toggle. Mixed words expose any swap of halves or nibbles.

One hard-reset frame is given a nonzero word count, and one data frame receives a second start request partway through. Both must keep their exact length and word-pull count.

// File: rtl/pd_bmc_pkg.sv
package pd_bmc_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PRE,
        TX_SYM,
        TX_TAIL
    } tx_state_e;

    // hard-reset ordered set symbols (sent LSB first)
    localparam logic [4:0] SYM_RESET_A = 5'b00111;
    localparam logic [4:0] SYM_RESET_B = 5'b11001;

endpackage

// File: rtl/pd_bmc_symlut.sv
module pd_bmc_symlut
    import pd_bmc_pkg::*;
(
    input  logic [3:0] nibble,
    input  logic       hrst_sel,
    input  logic       hrst_last,
    output logic [4:0] code
);

    always_comb begin
        if (hrst_sel) begin
            code = hrst_last ? SYM_RESET_B : SYM_RESET_A;
        end else begin
            case (nibble)
                4'h0: code = 5'b11110;
                4'h1: code = 5'b01001;
                4'h2: code = 5'b10100;
                4'h3: code = 5'b10101;
                4'h4: code = 5'b01010;
                4'h5: code = 5'b01011;
                4'h6: code = 5'b01110;
                4'h7: code = 5'b01111;
                4'h8: code = 5'b10010;
                4'h9: code = 5'b10011;
                4'hA: code = 5'b10110;
                4'hB: code = 5'b10111;
                4'hC: code = 5'b11010;
                4'hD: code = 5'b11011;
                4'hE: code = 5'b11100;
                default: code = 5'b11101;
            endcase
        end
    end

endmodule

// File: rtl/pd_bmc_encoder.sv
module pd_bmc_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic first_half,
    input  logic bit_val,
    input  logic force_low,
    output logic line
);

    logic line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (tick) begin
            if (force_low)       line_d = 1'b0;
            else if (first_half) line_d = ~line_q;
            else if (bit_val)    line_d = ~line_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_d;
    end

    assign line = line_q;

    // R2: no tick, no line change
    p_quiet_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line));

    // R2: every bit boundary carries a transition
    p_boundary_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && first_half && !force_low) |=> (line != $past(line)));

    // R6: tail end drives low
    p_tail_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_low) |=> !line);

endmodule

// File: rtl/pd_bmc_tx.sv
module pd_bmc_tx
    import pd_bmc_pkg::*;
#(
    parameter int PRE_BITS  = 64,
    parameter int WORDS_W   = 3,
    parameter int HRST_SYMS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               half_tick,
    input  logic               start_i,
    input  logic               frame_hrst_i,
    input  logic [WORDS_W-1:0] word_count_i,
    input  logic [31:0]        word_in_i,
    output logic               word_next_o,
    output logic               line_o,
    output logic               busy_o,
    output logic               done_o
);

    localparam int DATA_W       = 32;
    localparam int NIB_PER_WORD = DATA_W / 4;
    localparam int NIB_W        = $clog2(NIB_PER_WORD);
    localparam int PRE_W        = $clog2(PRE_BITS);
    localparam int SYM_BITS     = 5;

    typedef struct packed {
        tx_state_e          st;
        logic               kind;
        logic               half;
        logic [PRE_W-1:0]   bit_cnt;
        logic [2:0]         sym_bit;
        logic [NIB_W-1:0]   nib;
        logic [WORDS_W-1:0] words_left;
        logic [DATA_W-1:0]  word;
        logic               done;
        logic               word_next;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic       enc_tick, enc_first, enc_force, cur_bit;
    logic [3:0] nib_val;
    logic [4:0] sym_code;

    assign nib_val = ctl_q.word[{ctl_q.nib, 2'b00} +: 4];

    pd_bmc_symlut u_lut (
        .nibble    (nib_val),
        .hrst_sel  (ctl_q.kind),
        .hrst_last (ctl_q.nib == NIB_W'(HRST_SYMS - 1)),
        .code      (sym_code)
    );

    pd_bmc_encoder u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (enc_tick),
        .first_half (enc_first),
        .bit_val    (cur_bit),
        .force_low  (enc_force),
        .line       (line_o)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.done      = 1'b0;
        ctl_d.word_next = 1'b0;
        enc_tick        = 1'b0;
        enc_first       = 1'b0;
        enc_force       = 1'b0;
        cur_bit         = 1'b0;

        case (ctl_q.st)
            TX_IDLE: begin
                if (start_i) begin
                    ctl_d.st         = TX_PRE;
                    ctl_d.kind       = frame_hrst_i;
                    ctl_d.half       = 1'b0;
                    ctl_d.bit_cnt    = '0;
                    ctl_d.sym_bit    = '0;
                    ctl_d.nib        = '0;
                    ctl_d.words_left = word_count_i;
                    if (!frame_hrst_i && word_count_i != '0) begin
                        ctl_d.word      = word_in_i;
                        ctl_d.word_next = 1'b1;
                    end
                end
            end
            TX_PRE: begin
                cur_bit = ctl_q.bit_cnt[0];
                if (half_tick) begin
                    enc_tick   = 1'b1;
                    enc_first  = !ctl_q.half;
                    ctl_d.half = !ctl_q.half;
                    if (ctl_q.half) begin
                        if (ctl_q.bit_cnt == PRE_W'(PRE_BITS - 1)) begin
                            ctl_d.bit_cnt = '0;
                            ctl_d.st = (ctl_q.kind || ctl_q.words_left != '0) ? TX_SYM : TX_TAIL;
                        end else begin
                            ctl_d.bit_cnt = ctl_q.bit_cnt + 1'b1;
                        end
                    end
                end
            end
            TX_SYM: begin
                cur_bit = sym_code[ctl_q.sym_bit];
                if (half_tick) begin
                    enc_tick   = 1'b1;
                    enc_first  = !ctl_q.half;
                    ctl_d.half = !ctl_q.half;
                    if (ctl_q.half) begin
                        if (ctl_q.sym_bit == 3'(SYM_BITS - 1)) begin
                            ctl_d.sym_bit = '0;
                            if (ctl_q.kind) begin
                                if (ctl_q.nib == NIB_W'(HRST_SYMS - 1)) ctl_d.st = TX_TAIL;
                                else ctl_d.nib = ctl_q.nib + 1'b1;
                            end else if (ctl_q.nib == NIB_W'(NIB_PER_WORD - 1)) begin
                                ctl_d.nib        = '0;
                                ctl_d.words_left = ctl_q.words_left - 1'b1;
                                if (ctl_q.words_left == WORDS_W'(1)) begin
                                    ctl_d.st = TX_TAIL;
                                end else begin
                                    ctl_d.word      = word_in_i;
                                    ctl_d.word_next = 1'b1;
                                end
                            end else begin
                                ctl_d.nib = ctl_q.nib + 1'b1;
                            end
                        end else begin
                            ctl_d.sym_bit = ctl_q.sym_bit + 1'b1;
                        end
                    end
                end
            end
            default: begin // TX_TAIL
                if (half_tick) begin
                    enc_tick = 1'b1;
                    if (!ctl_q.half) begin
                        enc_first  = 1'b1;
                        ctl_d.half = 1'b1;
                    end else begin
                        enc_force  = 1'b1;
                        ctl_d.half = 1'b0;
                        ctl_d.st   = TX_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= TX_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = (ctl_q.st != TX_IDLE);
    assign done_o      = ctl_q.done;
    assign word_next_o = ctl_q.word_next;

    // R6: line parked low whenever idle
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == TX_IDLE) |-> !line_o);

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: words are only pulled during a frame
    p_word_pull_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_next_o |-> busy_o);

    // R9: a new request cannot cut a running frame short
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o && ctl_q.st != TX_TAIL) |=> busy_o);

    // R10: hard-reset frames never pull words
    p_hrst_no_words_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.kind) |-> !word_next_o);

endmodule

// File: tb/pd_bmc_tx_test.sv
module pd_bmc_tx_test;

    localparam int WORDS_W = 3;
    localparam int NFRAMES = 6;

    localparam logic [31:0] WORDS [4] = '{32'h7654_3210, 32'hFEDC_BA98, 32'hFFFF_0000, 32'hA5C3_1E78};
    // stimulus / expected vectors: kind, word count, tick count, mid-frame start poke
    localparam int FR_KIND  [NFRAMES] = '{1, 0, 0, 0, 1, 0};
    localparam int FR_N     [NFRAMES] = '{0, 1, 2, 0, 3, 3};
    localparam int FR_TICKS [NFRAMES] = '{170, 210, 290, 130, 170, 370};
    localparam int FR_POKE  [NFRAMES] = '{0, 1, 0, 0, 0, 0};

    logic clk = 0, rst_n = 0;
    logic half_tick = 0, start_i = 0, frame_hrst_i = 0;
    logic [WORDS_W-1:0] word_count_i = '0;
    logic [31:0] word_in_i = '0;
    logic word_next_o, line_o, busy_o, done_o;

    int checks = 0, fails = 0;

    always #2.5ns clk = ~clk;

    pd_bmc_tx #(.WORDS_W(WORDS_W)) uut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .start_i(start_i),
        .frame_hrst_i(frame_hrst_i), .word_count_i(word_count_i), .word_in_i(word_in_i),
        .word_next_o(word_next_o), .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] code4b5b(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011; 4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    // expected bit i of the frame (R3 preamble, R4 hard reset, R5 data)
    function automatic logic frame_bit(input int kind, input int i);
        logic [4:0] c;
        int j, s;
        if (i < 64) return logic'(i % 2);
        j = i - 64;
        s = j / 5;
        if (kind == 1) c = (s == 3) ? 5'b11001 : 5'b00111;
        else c = code4b5b(WORDS[s / 8][(s % 8) * 4 +: 4]);
        return c[j % 5];
    endfunction

    task automatic run_frame(input int kind, input int n, input int exp_ticks, input int poke);
        int wi = 0, wn = 0, t = 0, nbits, pre_bad = 0, pay_bad = 0, first_bad = -1;
        logic lvl = 0, done_seen = 0;
        nbits = 64 + 5 * ((kind == 1) ? 4 : 8 * n);
        word_in_i = WORDS[0];
        frame_hrst_i = logic'(kind);
        word_count_i = WORDS_W'(n);
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
        check(busy_o == 1, "R7 busy after start", busy_o, 1);
        if (word_next_o) begin wn++; wi++; if (wi < 4) word_in_i = WORDS[wi]; end
        while (busy_o && t < exp_ticks + 10) begin
            @(negedge clk) half_tick = 1;
            if (poke != 0 && t == 20) begin start_i = 1; frame_hrst_i = 1; word_count_i = '1; end // R9
            @(negedge clk) begin half_tick = 0; start_i = 0; end
            if (t < 2 * nbits) begin
                if (t % 2 == 0) lvl = ~lvl;
                else if (frame_bit(kind, t / 2)) lvl = ~lvl;
            end else if (t == 2 * nbits) lvl = ~lvl;
            else lvl = 0;
            if (line_o !== lvl) begin
                if (t < 128) pre_bad++; else pay_bad++;
                if (first_bad < 0) first_bad = t;
            end
            if (word_next_o) begin wn++; wi++; if (wi < 4) word_in_i = WORDS[wi]; end
            t++;
            if (t == exp_ticks) done_seen = done_o;
            @(negedge clk);
            if (line_o !== lvl) pay_bad++; // R2: stable between ticks
        end
        check(pre_bad == 0, "R2 R3 preamble cells", pre_bad, 0);
        check(pay_bad == 0, (kind == 1) ? "R2 R4 hard-reset cells" : "R2 R5 data cells", first_bad, -1);
        check(t == exp_ticks, "R7 frame length", t, exp_ticks);
        check(done_seen == 1 && busy_o == 0, "R7 done pulse", done_seen, 1);
        check(line_o == 0, "R6 idle low after tail", line_o, 0);
        check(wn == ((kind == 1) ? 0 : n), "R8 R10 word pulls", wn, (kind == 1) ? 0 : n);
        frame_hrst_i = 0;
        word_count_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(line_o == 0 && busy_o == 0 && done_o == 0 && word_next_o == 0, "R1 reset outputs",
              {line_o, busy_o, done_o, word_next_o}, 0);
        @(negedge clk) rst_n = 1;
        // R2: ticks while idle leave the line alone
        repeat (6) begin
            @(negedge clk) half_tick = 1;
            @(negedge clk) half_tick = 0;
        end
        check(line_o == 0 && busy_o == 0, "R2 idle ticks ignored", line_o, 0);
        for (int f = 0; f < NFRAMES; f++) begin
            run_frame(FR_KIND[f], FR_N[f], FR_TICKS[f], FR_POKE[f]);
            repeat (3) @(negedge clk);
        end
        // R6: line remains low long after a frame
        repeat (10) @(negedge clk);
        check(line_o == 0 && busy_o == 0, "R6 parked low", line_o, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule